// File: doc/BRIEF.md
# Branch Delay-Slot Fetch Sequencer

This block produces the instruction fetch address for a 64-bit core whose branches carry one architectural delay slot. Out of reset it fetches from a fixed boot address, and it steps by one 32-bit word each time a memory read completes. When a branch resolves as taken, the program counter jumps to the target at once. The address of the delay-slot instruction, which is the already-stepped counter, goes into a side register, and that slot is fetched next. A "likely" branch that is not taken cancels its delay slot. The next issue slot then hands out an all-zero word (a NOP) without touching memory.

The memory side uses a request/ready handshake with a fault flag. A faulting read reports the address that was fetched and does not advance the sequence. An exception or other redirect comes in through a single load port. That port overrides everything else in the cycle it is asserted. A 64-bit counter charges three cycles for each branch resolution. A sticky flag reports a second branch that resolves while a delay slot is still outstanding.

The sequencing is held in a three-state machine:
- SLOT_NONE: ordinary sequential fetch at the program counter.
- SLOT_FETCH: a delay-slot read is pending at the saved address.
- SLOT_NOP: a nullified slot is pending.

It has four transitions:
- T_TAKEN: any state to SLOT_FETCH on an accepted taken branch.
- T_SKIP: to SLOT_NOP on an accepted not-taken likely branch.
- T_CONSUME: SLOT_FETCH or SLOT_NOP back to SLOT_NONE when the slot is issued.
- T_LOAD: any state to SLOT_NONE on a load.

Top module: `dslot_fetch_seq`

## Requirements
- R1: After reset the fetch address is 0xFFFFFFFF_BFC00000, the state is SLOT_NONE (a read is requested), the cycle count is 0 and the overlap flag is 0.
- R2: In SLOT_NONE, a read that completes without a fault presents the word that memory returned and advances the program counter by 4.
- R3: A taken branch saves the program counter, after any advance made in the same cycle, as the delay-slot address. It sets the counter to that value plus the sign-extended immediate shifted left by 2. A not-taken branch without the likely flag changes nothing but the cycle count.
- R4: In SLOT_FETCH the read goes to the saved delay-slot address. Completing it does not move the program counter and returns the state to SLOT_NONE, so the following fetch is at the branch target.
- R5: After a not-taken likely branch, the next issue cycle raises instr_valid with instr_word all zero and fetch_req low. The program counter advances by 4 and the state returns to SLOT_NONE, all in that one cycle.
- R6: A read completing with fetch_fault high raises fault_valid for that cycle and does not raise instr_valid. fault_addr is the delay-slot address in SLOT_FETCH and the program counter otherwise, and neither the counter nor the state changes.
- R7: Every cycle with br_valid high adds 3 to cycle_count.
- R8: A branch that resolves while a slot is still pending after this cycle's issue sets overlap_err, which stays set until reset. The branch has no other effect: the first delay-slot address and the program counter are kept.
- R9: ld_valid loads the program counter from ld_addr and forces SLOT_NONE, whatever else happens in that cycle. A read completing in that cycle is still presented.
- R10: While a read is requested and not yet ready, and no branch or load arrives, fetch_addr holds its value.
- R11: When a branch resolves in the same cycle that a slot is issued or a sequential read completes, the branch acts on the state after that issue: the saved slot address is the advanced counter, and no overlap is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| br_likely | input | 1 | The resolving branch cancels its slot when not taken |
| br_imm | input | 16 | Branch immediate in words, signed |
| ld_valid | input | 1 | Load the program counter (redirect) |
| ld_addr | input | 64 | Address loaded by ld_valid |
| fetch_req | output | 1 | A memory read is requested |
| fetch_addr | output | 64 | Address of the requested read |
| fetch_ready | input | 1 | The memory completes the read this cycle |
| fetch_fault | input | 1 | The completing read faulted |
| fetch_rdata | input | 32 | Word returned by memory |
| instr_valid | output | 1 | An instruction word is issued this cycle |
| instr_word | output | 32 | Issued word, zero for a nullified slot |
| fault_valid | output | 1 | A read faulted this cycle |
| fault_addr | output | 64 | Address of the faulting read |
| cycle_count | output | 64 | Accumulated branch cost |
| overlap_err | output | 1 | Sticky flag for a branch during a pending slot |

## Verification
The case that most needs attention is a branch resolution that falls in the same cycle as the issue of a fetch. The bench provokes it by resolving a taken branch while a sequential read completes. It then checks that the slot fetched next is the advanced address and that the following fetch lands at the target computed from that address. It also resolves a likely branch in a completing cycle and places a second branch behind a still-waiting slot read, so that the overlap flag and the kept slot address are judged against a slot that was not yet issued. A load arriving together with a branch and a completing read shows that the read is presented and the load wins.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_FETCH = 2'd1,
        SLOT_NOP   = 2'd2
    } slot_e;

endpackage

// File: rtl/fseq_target.sv
module fseq_target #(
    parameter int ADDR_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target
);
    localparam int OFF_W = IMM_W + 2;
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target = base + offset;
    end

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
    parameter int                ADDR_W   = 64,
    parameter int                IMM_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 64'hFFFF_FFFF_BFC0_0000,
    parameter int                STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_adv,
    input  logic              take,
    input  logic [IMM_W-1:0]  imm,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] pc_base
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc_next;

    fseq_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_target (
        .base   (pc_base),
        .imm    (imm),
        .target (target)
    );

    always_comb begin
        pc_base = seq_adv ? pc + STEP_V : pc;
        if (ld_valid)
            pc_next = ld_addr;
        else if (take)
            pc_next = target;
        else
            pc_next = pc_base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else
            pc <= pc_next;
    end

    // R2: a plain sequential advance steps by one word
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_adv && !take && !ld_valid) |=> (pc == $past(pc) + STEP_V));

    // R9: a load always wins
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (pc == $past(ld_addr)));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_ok,
    input  logic              br_valid,
    input  logic              br_taken,
    input  logic              br_likely,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] pc_base,
    output slot_e             state,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              seq_adv,
    output logic              take,
    output logic              overlap_err
);
    slot_e state_next;
    slot_e after_issue;
    logic  consume;
    logic  br_free;
    logic  overlap;

    always_comb begin
        consume = 1'b0;
        seq_adv = 1'b0;
        unique case (state)
            SLOT_NONE: begin
                seq_adv = done_ok;
            end
            SLOT_FETCH: begin
                consume = done_ok;
            end
            SLOT_NOP: begin
                consume = 1'b1;
                seq_adv = 1'b1;
            end
            default: begin
                consume = 1'b0;
            end
        endcase

        after_issue = consume ? SLOT_NONE : state;
        br_free     = br_valid && !ld_valid && (after_issue == SLOT_NONE);
        overlap     = br_valid && !ld_valid && (after_issue != SLOT_NONE);
        take        = br_free && br_taken;

        if (ld_valid)
            state_next = SLOT_NONE;                 // T_LOAD
        else if (take)
            state_next = SLOT_FETCH;                // T_TAKEN
        else if (br_free && br_likely)
            state_next = SLOT_NOP;                  // T_SKIP
        else
            state_next = after_issue;               // T_CONSUME or hold
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SLOT_NONE;
            slot_addr   <= '0;
            overlap_err <= 1'b0;
        end else begin
            state <= state_next;
            if (take)
                slot_addr <= pc_base;
            if (overlap)
                overlap_err <= 1'b1;
        end
    end

    // R8: the overlap flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err);

    // R8: an overlapping branch keeps the first slot address
    p_slot_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_FETCH && !done_ok && br_valid && !ld_valid)
            |=> ($stable(slot_addr) && overlap_err && state == SLOT_FETCH));

    // R9: a load returns the machine to sequential fetch
    p_load_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (state == SLOT_NONE));

endmodule

// File: rtl/fseq_cost_ctr.sv
module fseq_cost_ctr #(
    parameter int CNT_W = 64,
    parameter int COST  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] COST_V = CNT_W'(COST);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (br_valid)
            count <= count + COST_V;
    end

    // R7: each branch resolution is charged a fixed cost
    p_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (count == $past(count) + COST_V));

    p_idle_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> $stable(count));

endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
    import fseq_pkg::*;
#(
    parameter int                ADDR_W   = 64,
    parameter int                INSTR_W  = 32,
    parameter int                IMM_W    = 16,
    parameter int                CNT_W    = 64,
    parameter int                BR_COST  = 3,
    parameter int                STEP     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = 64'hFFFF_FFFF_BFC0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_valid,
    input  logic               br_taken,
    input  logic               br_likely,
    input  logic [IMM_W-1:0]   br_imm,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_ready,
    input  logic               fetch_fault,
    input  logic [INSTR_W-1:0] fetch_rdata,
    output logic               instr_valid,
    output logic [INSTR_W-1:0] instr_word,
    output logic               fault_valid,
    output logic [ADDR_W-1:0]  fault_addr,
    output logic [CNT_W-1:0]   cycle_count,
    output logic               overlap_err
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    slot_e             state;
    logic [ADDR_W-1:0] slot_addr;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] pc_base;
    logic              seq_adv;
    logic              take;
    logic              mem_done;
    logic              done_ok;

    always_comb begin
        fetch_req   = (state != SLOT_NOP);
        fetch_addr  = (state == SLOT_FETCH) ? slot_addr : pc;
        mem_done    = fetch_req && fetch_ready;
        done_ok     = mem_done && !fetch_fault;
        fault_valid = mem_done && fetch_fault;
        fault_addr  = fetch_addr;
        instr_valid = done_ok || (state == SLOT_NOP);
        instr_word  = (state == SLOT_NOP) ? '0 : fetch_rdata;
    end

    fseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_ok     (done_ok),
        .br_valid    (br_valid),
        .br_taken    (br_taken),
        .br_likely   (br_likely),
        .ld_valid    (ld_valid),
        .pc_base     (pc_base),
        .state       (state),
        .slot_addr   (slot_addr),
        .seq_adv     (seq_adv),
        .take        (take),
        .overlap_err (overlap_err)
    );

    fseq_pc #(
        .ADDR_W   (ADDR_W),
        .IMM_W    (IMM_W),
        .RESET_PC (RESET_PC),
        .STEP     (STEP)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_adv  (seq_adv),
        .take     (take),
        .imm      (br_imm),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .pc       (pc),
        .pc_base  (pc_base)
    );

    fseq_cost_ctr #(.CNT_W(CNT_W), .COST(BR_COST)) u_cost (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_valid (br_valid),
        .count    (cycle_count)
    );

    // R4: a completed slot read leaves the counter where the branch put it
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_FETCH && fetch_ready && !fetch_fault && !br_valid && !ld_valid)
            |=> (state == SLOT_NONE && pc == $past(pc)));

    // R5: a nullified slot issues in one cycle and steps the counter
    p_nop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_NOP && !br_valid && !ld_valid)
            |=> (state == SLOT_NONE && pc == $past(pc) + STEP_V));

    p_nop_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_NOP) |-> (instr_valid && instr_word == '0));

    // R6: a fault during a slot read reports the saved slot address
    p_fault_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && state == SLOT_FETCH) |-> (fault_addr == slot_addr));

    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !br_valid && !ld_valid) |=> ($stable(pc) && $stable(state)));

    // R10: a waiting read keeps its address
    p_stable_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready && !br_valid && !ld_valid) |=> $stable(fetch_addr));

endmodule

// File: tb/dslot_fetch_seq_bench.sv
module dslot_fetch_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] RST = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [63:0] LDA = 64'h0000_0000_8000_0080;
    localparam logic [63:0] LDB = 64'h0000_0000_0000_1000;

    typedef struct packed {
        logic        nop;
        logic [63:0] addr;
        logic [7:0]  req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, br_taken = 1'b0, br_likely = 1'b0;
    logic [15:0] br_imm = '0;
    logic        ld_valid = 1'b0;
    logic [63:0] ld_addr = '0;
    logic        fetch_req;
    logic [63:0] fetch_addr;
    logic        fetch_ready = 1'b0, fetch_fault = 1'b0;
    logic [31:0] fetch_rdata;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        fault_valid;
    logic [63:0] fault_addr;
    logic [63:0] cycle_count;
    logic        overlap_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ 32'h1234_5679;
    endfunction

    assign fetch_rdata = mem_word(fetch_addr);

    dslot_fetch_seq u_dslot_fetch_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_valid    (br_valid),
        .br_taken    (br_taken),
        .br_likely   (br_likely),
        .br_imm      (br_imm),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_ready (fetch_ready),
        .fetch_fault (fetch_fault),
        .fetch_rdata (fetch_rdata),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .fault_valid (fault_valid),
        .fault_addr  (fault_addr),
        .cycle_count (cycle_count),
        .overlap_err (overlap_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic nop, input logic [63:0] a, input int req);
        item_t it;
        it.nop  = nop;
        it.addr = a;
        it.req  = 8'(req);
        exp_q.push_back(it);
    endtask

    // Drive one cycle of inputs after an edge; return at the following falling edge.
    task automatic cyc(input logic rdy, input logic flt, input logic bv, input logic tk,
                       input logic lk, input logic [15:0] imm, input logic lv,
                       input logic [63:0] la);
        @(posedge clk);
        #1;
        fetch_ready = rdy;
        fetch_fault = flt;
        br_valid    = bv;
        br_taken    = tk;
        br_likely   = lk;
        br_imm      = imm;
        ld_valid    = lv;
        ld_addr     = la;
        @(negedge clk);
    endtask

    task automatic idle(input logic rdy);
        cyc(rdy, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 64'h0);
    endtask

    // Monitor: pops the scoreboard whenever an instruction is issued.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && instr_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected issue: actual addr %h word %h expected none",
                         fetch_addr, instr_word);
            end else begin
                it = exp_q.pop_front();
                if (it.nop) begin
                    if (instr_word !== 32'h0 || fetch_req !== 1'b0) begin
                        n_fail++;
                        $display("FAIL R%0d nullified slot: actual word %h req %b expected word 0 req 0",
                                 it.req, instr_word, fetch_req);
                    end
                end else if (fetch_addr !== it.addr || instr_word !== mem_word(it.addr)) begin
                    n_fail++;
                    $display("FAIL R%0d issue: actual addr %h word %h expected addr %h word %h",
                             it.req, fetch_addr, instr_word, it.addr, mem_word(it.addr));
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset fetch_addr", fetch_addr, RST);
        chk("R1", "reset fetch_req", 64'(fetch_req), 64'd1);
        chk("R1", "reset count", cycle_count, 64'd0);
        chk("R1", "reset overlap", 64'(overlap_err), 64'd0);

        // R2: sequential reads
        push(1'b0, RST, 2);
        idle(1'b1);
        push(1'b0, RST + 4, 2);
        idle(1'b1);
        // R11, R3: taken branch together with a completing read
        push(1'b0, RST + 8, 11);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd16, 1'b0, 64'h0);
        // R4: slot read at the advanced address, then the target
        push(1'b0, RST + 12, 4);
        idle(1'b1);
        push(1'b0, RST + 76, 4);
        idle(1'b1);
        chk("R7", "count after one branch", cycle_count, 64'd3);

        // R3: backward branch while the read waits
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFF0, 1'b0, 64'h0);
        chk("R10", "addr before branch", fetch_addr, RST + 80);
        push(1'b0, RST + 80, 3);
        idle(1'b1);
        push(1'b0, RST + 16, 3);
        idle(1'b1);

        // R5: likely branch not taken, slot becomes a NOP
        push(1'b0, RST + 20, 5);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'd40, 1'b0, 64'h0);
        push(1'b1, 64'h0, 5);
        idle(1'b0);
        chk("R5", "no read in nullified slot", 64'(fetch_req), 64'd0);
        // R3: plain not-taken branch has no effect on the sequence
        push(1'b0, RST + 28, 3);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd40, 1'b0, 64'h0);
        push(1'b0, RST + 32, 3);
        idle(1'b1);

        // R8: second branch while the slot read is still waiting
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd8, 1'b0, 64'h0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd100, 1'b0, 64'h0);
        push(1'b0, RST + 36, 8);
        idle(1'b1);
        chk("R8", "overlap flag", 64'(overlap_err), 64'd1);
        push(1'b0, RST + 68, 8);
        idle(1'b1);

        // R6: fault during a sequential read
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 64'h0);
        chk("R6", "seq fault valid", 64'(fault_valid), 64'd1);
        chk("R6", "seq fault addr", fault_addr, RST + 72);
        chk("R6", "no issue on fault", 64'(instr_valid), 64'd0);
        push(1'b0, RST + 72, 6);
        idle(1'b1);
        // R6: fault during a slot read
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd4, 1'b0, 64'h0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 64'h0);
        chk("R6", "slot fault addr", fault_addr, RST + 76);
        push(1'b0, RST + 76, 6);
        idle(1'b1);

        // R9: load with a branch and a completing read in the same cycle
        push(1'b0, RST + 92, 9);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2, 1'b1, LDA);
        push(1'b0, LDA, 9);
        idle(1'b1);
        // R10: a waiting slot read keeps its address
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd8, 1'b0, 64'h0);
        chk("R10", "addr at branch", fetch_addr, LDA + 4);
        idle(1'b0);
        chk("R10", "addr while waiting", fetch_addr, LDA + 4);
        // R9: load cancels a pending slot
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, LDB);
        push(1'b0, LDB, 9);
        idle(1'b1);
        idle(1'b0);

        chk("R7", "final count", cycle_count, 64'd27);
        chk("R8", "overlap still set", 64'(overlap_err), 64'd1);
        chk("R2", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule